// File: doc/BRIEF.md
# Snoop Response Controller for a Three-State Write-Back Cache

This block decides how a write-back data cache reacts to transactions seen on a shared bus. Each cache line is in one of three states: invalid, exclusive (clean and owned) or modified (dirty and owned). The block holds a small fully associative tag store. Lines are written into it by a line-fill sequencer. For each snooped address the block looks up the line and decodes the transaction kind together with its global, caching-inhibited and burst attributes. From these it produces four responses: an address-retry, a copyback (push) request, a line-state update and a reservation-cancel pulse.

The end of a line fill rewrites a tag, and a snoop cannot be served while that happens. The block therefore retries snoops in a one-cycle collision window. The position of that window depends on a mode input: it is either the final data-acknowledge cycle of the fill or the cycle after it.

A snoop that needs a dirty line written back is retried. The block then raises a push request and holds it until the data mover acknowledges. The new line state is committed only on that acknowledge. Every active snoop that arrives while the push is outstanding is retried.

Top module: `snp_resp_ctrl`

## Requirements
- R1: A flush (kind 5) or clean (kind 6) that hits a modified line is retried and starts a push. After the push, the line is invalid for flush and exclusive for clean. A flush that hits an exclusive line invalidates it without retry. A clean that hits an exclusive line changes nothing.
- R2: A kill (kind 7) that hits a line makes it invalid. A kill never starts a push, and it is never retried outside the collision window and outside a pending push.
- R3: With `late_window`=0, every active snoop (kind 0 to 7) in the cycle where `fill_ack_last` is high is retried and updates nothing. The filled tag is written at the end of that cycle.
- R4: With `late_window`=1, the cycle where `fill_ack_last` is high serves snoops normally. Every active snoop in the following cycle is retried and updates nothing. The filled tag is written at the end of that following cycle.
- R5: A write-with-kill (kind 4) that hits a line makes it invalid even if modified. It does so with no push and no retry. It pulses `resv_cancel` in the same cycle when `resv_valid` is high and `resv_addr` equals `snp_addr`.
- R6: A read (kind 0) or read-atomic (kind 1) that is not caching-inhibited and has `snp_global` or `snp_burst` set acts by line state as follows. An exclusive line becomes invalid. A modified line is pushed and then becomes invalid. With neither attribute set, such a read changes nothing.
- R7: A caching-inhibited read or read-atomic (`snp_inhibit`=1, which takes precedence over the other attributes) acts as follows. An exclusive line stays exclusive with no retry. A modified line is pushed and then becomes exclusive.
- R8: A read-with-intent-to-modify (kind 2) or its atomic form (kind 3) acts as follows. An exclusive line becomes invalid. A modified line is pushed and then becomes invalid.
- R9: Sync (kind 8), TLB-invalidate (kind 9) and the unused kinds 10 to 15 never retry, never cancel a reservation and never change a line.
- R10: A push starts as follows. `push_req` rises in the cycle after the retried snoop and carries that snoop's address on `push_addr`. It stays high until a cycle with `push_ack` high, in which `upd_valid` reports the committed state; it is low in the next cycle. While it is high, every active snoop is retried.
- R11: A snoop whose address matches no valid line produces no retry, no update and no cancel. A hit that is not a write-with-kill never pulses `resv_cancel`.
- R12: After reset every line is invalid, and `snp_retry`, `push_req`, `upd_valid` and `resv_cancel` are low.
- R13: State codes on `fill_state` and `upd_state` are invalid=0, exclusive=1, modified=2. A direct update (no push) pulses `upd_valid` with `upd_slot`/`upd_state` in the snoop's own cycle, and only when the state changes. The new state is used from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | A snooped transaction is present this cycle |
| snp_kind | input | 4 | Transaction kind code (see R1 to R9) |
| snp_addr | input | AW | Snooped line address |
| snp_global | input | 1 | Transaction marked global |
| snp_inhibit | input | 1 | Transaction marked caching-inhibited |
| snp_burst | input | 1 | Transaction is a burst |
| late_window | input | 1 | Collision window mode: 0 ack cycle, 1 cycle after |
| fill_ack_last | input | 1 | Final data-acknowledge beat of a line fill |
| fill_slot | input | log2(LINES) | Tag store slot the fill writes |
| fill_addr | input | AW | Line address the fill installs |
| fill_state | input | 2 | State the fill installs |
| resv_valid | input | 1 | A reservation is held |
| resv_addr | input | AW | Line address of the reservation |
| push_ack | input | 1 | Data mover has finished the push |
| snp_retry | output | 1 | Address-retry for the current snoop |
| push_req | output | 1 | Copyback request pending |
| push_addr | output | AW | Line address of the pending copyback |
| upd_valid | output | 1 | A line state is written this cycle |
| upd_slot | output | log2(LINES) | Slot being updated |
| upd_state | output | 2 | New state being written |
| resv_cancel | output | 1 | Reservation cancel pulse |

## Verification
The address-retry, the reservation cancel and a direct state update all belong to the snoop's own cycle. The bench drives each snoop just after the falling edge and samples these outputs a quarter period later, before the next rising edge. `push_req` and `push_addr` are registered, so they are checked one cycle after the retried snoop. The committed update is checked in the cycle where the bench holds `push_ack`, and the drop of `push_req` one cycle after that. The reference model updates its copy of the line states only after the rising edge that ends the cycle the requirements name. In the late mode this includes the tag write one cycle after the last acknowledge, so later snoops are predicted against the state the design should actually hold.

// File: rtl/snp_pkg.sv
package snp_pkg;

   typedef enum logic [1:0] {
      LN_INV = 2'd0,
      LN_EXC = 2'd1,
      LN_MOD = 2'd2,
      LN_RSV = 2'd3
   } line_st_e;

   typedef enum logic [3:0] {
      SK_READ     = 4'd0,
      SK_READ_AT  = 4'd1,
      SK_RWITM    = 4'd2,
      SK_RWITM_AT = 4'd3,
      SK_WKILL    = 4'd4,
      SK_FLUSH    = 4'd5,
      SK_CLEAN    = 4'd6,
      SK_KILL     = 4'd7,
      SK_SYNC     = 4'd8,
      SK_TLBI     = 4'd9
   } snp_kind_e;

   typedef struct packed {
      logic     push;
      logic     drop_resv;
      line_st_e nxt;
   } snp_act_t;

   function automatic logic kind_active(input logic [3:0] k);
      return k <= 4'd7;
   endfunction

endpackage

// File: rtl/snp_tag_store.sv
module snp_tag_store
   import snp_pkg::*;
#(
   parameter int LINES = 4,
   parameter int AW    = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [AW-1:0]            look_addr,
   output logic                     look_hit,
   output logic [$clog2(LINES)-1:0] look_slot,
   output line_st_e                 look_st,
   input  logic                     tw_en,
   input  logic [$clog2(LINES)-1:0] tw_slot,
   input  logic [AW-1:0]            tw_addr,
   input  line_st_e                 tw_st,
   input  logic                     sw_en,
   input  logic [$clog2(LINES)-1:0] sw_slot,
   input  line_st_e                 sw_st
);
   localparam int IW = $clog2(LINES);

   logic [LINES-1:0][1:0]    st_v;
   logic [LINES-1:0][AW-1:0] tag_v;
   logic [LINES-1:0]         match;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      line_st_e      st_r;
      logic [AW-1:0] tag_r;
      logic          tw_hit;
      logic          sw_hit;

      assign tw_hit = tw_en && (tw_slot == IW'(g));
      assign sw_hit = sw_en && (sw_slot == IW'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_r  <= LN_INV;
            tag_r <= '0;
         end else if (tw_hit) begin
            st_r  <= tw_st;
            tag_r <= tw_addr;
         end else if (sw_hit) begin
            st_r  <= sw_st;
         end
      end

      assign st_v[g]  = st_r;
      assign tag_v[g] = tag_r;
      assign match[g] = (st_r != LN_INV) && (tag_r == look_addr);
   end

   always_comb begin
      look_slot = '0;
      for (int i = LINES - 1; i >= 0; i--) begin
         if (match[i]) look_slot = IW'(i);
      end
      look_hit = |match;
      look_st  = line_st_e'(st_v[look_slot]);
   end

endmodule

// File: rtl/snp_action_dec.sv
module snp_action_dec
   import snp_pkg::*;
(
   input  logic [3:0] kind,
   input  logic       glob,
   input  logic       inhib,
   input  logic       burst,
   input  line_st_e   cur,
   output snp_act_t   act
);
   logic dirty;
   assign dirty = (cur == LN_MOD);

   always_comb begin
      act.push      = 1'b0;
      act.drop_resv = 1'b0;
      act.nxt       = cur;
      if (cur != LN_INV) begin
         case (kind)
            SK_READ, SK_READ_AT: begin
               if (inhib) begin
                  if (dirty) begin
                     act.push = 1'b1;
                     act.nxt  = LN_EXC;
                  end
               end else if (glob || burst) begin
                  act.push = dirty;
                  act.nxt  = LN_INV;
               end
            end
            SK_RWITM, SK_RWITM_AT, SK_FLUSH: begin
               act.push = dirty;
               act.nxt  = LN_INV;
            end
            SK_CLEAN: begin
               if (dirty) begin
                  act.push = 1'b1;
                  act.nxt  = LN_EXC;
               end
            end
            SK_WKILL: begin
               act.drop_resv = 1'b1;
               act.nxt       = LN_INV;
            end
            SK_KILL: begin
               act.nxt = LN_INV;
            end
            default: begin
               act.nxt = cur;
            end
         endcase
      end
   end

endmodule

// File: rtl/snp_fill_window.sv
module snp_fill_window
   import snp_pkg::*;
#(
   parameter int LINES    = 4,
   parameter int AW       = 12,
   parameter bit HAS_LATE = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     late_mode,
   input  logic                     ack_last,
   input  logic [$clog2(LINES)-1:0] f_slot,
   input  logic [AW-1:0]            f_addr,
   input  line_st_e                 f_st,
   output logic                     window,
   output logic                     tw_en,
   output logic [$clog2(LINES)-1:0] tw_slot,
   output logic [AW-1:0]            tw_addr,
   output line_st_e                 tw_st
);
   localparam int IW = $clog2(LINES);

   if (HAS_LATE) begin : g_late
      logic          dly_v;
      logic [IW-1:0] dly_slot;
      logic [AW-1:0] dly_addr;
      line_st_e      dly_st;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            dly_v    <= 1'b0;
            dly_slot <= '0;
            dly_addr <= '0;
            dly_st   <= LN_INV;
         end else begin
            dly_v    <= ack_last && late_mode;
            dly_slot <= f_slot;
            dly_addr <= f_addr;
            dly_st   <= f_st;
         end
      end

      assign window  = (ack_last && !late_mode) || dly_v;
      assign tw_en   = window;
      assign tw_slot = dly_v ? dly_slot : f_slot;
      assign tw_addr = dly_v ? dly_addr : f_addr;
      assign tw_st   = dly_v ? dly_st   : f_st;
   end else begin : g_early
      logic unused_mode;
      assign unused_mode = late_mode;
      assign window  = ack_last;
      assign tw_en   = ack_last;
      assign tw_slot = f_slot;
      assign tw_addr = f_addr;
      assign tw_st   = f_st;
   end

endmodule

// File: rtl/snp_resp_ctrl.sv
module snp_resp_ctrl
   import snp_pkg::*;
#(
   parameter int LINES    = 4,
   parameter int AW       = 12,
   parameter bit HAS_LATE = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     snp_valid,
   input  logic [3:0]               snp_kind,
   input  logic [AW-1:0]            snp_addr,
   input  logic                     snp_global,
   input  logic                     snp_inhibit,
   input  logic                     snp_burst,
   input  logic                     late_window,
   input  logic                     fill_ack_last,
   input  logic [$clog2(LINES)-1:0] fill_slot,
   input  logic [AW-1:0]            fill_addr,
   input  logic [1:0]               fill_state,
   input  logic                     resv_valid,
   input  logic [AW-1:0]            resv_addr,
   input  logic                     push_ack,
   output logic                     snp_retry,
   output logic                     push_req,
   output logic [AW-1:0]            push_addr,
   output logic                     upd_valid,
   output logic [$clog2(LINES)-1:0] upd_slot,
   output logic [1:0]               upd_state,
   output logic                     resv_cancel
);
   localparam int IW = $clog2(LINES);

   if (LINES < 2) begin : g_bad_lines
      $error("snp_resp_ctrl: LINES must be at least 2");
   end
   if (AW < 2) begin : g_bad_aw
      $error("snp_resp_ctrl: AW must be at least 2");
   end

   typedef enum logic {PS_IDLE = 1'b0, PS_PUSH = 1'b1} push_st_e;

   logic          look_hit;
   logic [IW-1:0] look_slot;
   line_st_e      look_st;
   snp_act_t      act;
   logic          window;
   logic          tw_en;
   logic [IW-1:0] tw_slot;
   logic [AW-1:0] tw_addr;
   line_st_e      tw_st;

   push_st_e      ps_q;
   logic [IW-1:0] pslot_q;
   line_st_e      pst_q;
   logic [AW-1:0] paddr_q;

   logic          busy;
   logic          active;
   logic          accept;
   logic          commit_push;
   logic          imm_upd;
   line_st_e      upd_st_e;

   snp_fill_window #(.LINES(LINES), .AW(AW), .HAS_LATE(HAS_LATE)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .late_mode (late_window),
      .ack_last  (fill_ack_last),
      .f_slot    (fill_slot),
      .f_addr    (fill_addr),
      .f_st      (line_st_e'(fill_state)),
      .window    (window),
      .tw_en     (tw_en),
      .tw_slot   (tw_slot),
      .tw_addr   (tw_addr),
      .tw_st     (tw_st)
   );

   snp_tag_store #(.LINES(LINES), .AW(AW)) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .look_addr (snp_addr),
      .look_hit  (look_hit),
      .look_slot (look_slot),
      .look_st   (look_st),
      .tw_en     (tw_en),
      .tw_slot   (tw_slot),
      .tw_addr   (tw_addr),
      .tw_st     (tw_st),
      .sw_en     (upd_valid),
      .sw_slot   (upd_slot),
      .sw_st     (upd_st_e)
   );

   snp_action_dec u_dec (
      .kind  (snp_kind),
      .glob  (snp_global),
      .inhib (snp_inhibit),
      .burst (snp_burst),
      .cur   (look_st),
      .act   (act)
   );

   assign busy   = (ps_q == PS_PUSH);
   assign active = snp_valid && kind_active(snp_kind);
   assign accept = active && !busy && !window && look_hit;

   assign snp_retry   = active && (busy || window || (look_hit && act.push));
   assign resv_cancel = accept && act.drop_resv && resv_valid && (resv_addr == snp_addr);

   assign commit_push = busy && push_ack;
   assign imm_upd     = accept && !act.push && (act.nxt != look_st);
   assign upd_valid   = commit_push || imm_upd;
   assign upd_slot    = commit_push ? pslot_q : look_slot;
   assign upd_st_e    = commit_push ? pst_q : act.nxt;
   assign upd_state   = upd_st_e;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ps_q    <= PS_IDLE;
         pslot_q <= '0;
         pst_q   <= LN_INV;
         paddr_q <= '0;
      end else if (accept && act.push) begin
         ps_q    <= PS_PUSH;
         pslot_q <= look_slot;
         pst_q   <= act.nxt;
         paddr_q <= snp_addr;
      end else if (commit_push) begin
         ps_q    <= PS_IDLE;
      end
   end

   assign push_req  = busy;
   assign push_addr = paddr_q;

endmodule

// File: rtl/snp_resp_chk.sv
module snp_resp_chk #(
   parameter int AW       = 12,
   parameter bit HAS_LATE = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          snp_valid,
   input logic [3:0]    snp_kind,
   input logic [AW-1:0] snp_addr,
   input logic          late_window,
   input logic          fill_ack_last,
   input logic          resv_valid,
   input logic [AW-1:0] resv_addr,
   input logic          push_ack,
   input logic          snp_retry,
   input logic          push_req,
   input logic          upd_valid,
   input logic          resv_cancel
);

   assert_kill_no_retry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid && snp_kind == 4'd7 && !push_req && !fill_ack_last && !late_window
      |-> !snp_retry);

   assert_early_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !late_window && fill_ack_last && snp_valid && snp_kind <= 4'd7 |-> snp_retry);

   if (HAS_LATE) begin : g_late_chk
      assert_late_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
         late_window && $past(late_window) && $past(fill_ack_last)
         && snp_valid && snp_kind <= 4'd7 |-> snp_retry);
   end

   assert_cancel_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      resv_cancel |-> snp_valid && snp_kind == 4'd4 && resv_valid && resv_addr == snp_addr);

   assert_quiet_kinds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid && snp_kind >= 4'd8 |-> !snp_retry && !resv_cancel);

   assert_push_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      push_req && !push_ack |=> push_req);

   assert_push_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      push_req && push_ack |-> upd_valid);

   assert_busy_retry_R10: assert property (@(posedge clk) disable iff (!rst_n)
      push_req && snp_valid && snp_kind <= 4'd7 |-> snp_retry);

   assert_push_after_retry_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(push_req) |-> $past(snp_retry));

endmodule

bind snp_resp_ctrl snp_resp_chk #(.AW(AW), .HAS_LATE(HAS_LATE)) u_chk (.*);

// File: tb/tb_snp_resp_ctrl.sv
module tb_snp_resp_ctrl;
   localparam int LINES = 4;
   localparam int AW    = 12;
   localparam int IW    = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          snp_valid = 1'b0;
   logic [3:0]    snp_kind = '0;
   logic [AW-1:0] snp_addr = '0;
   logic          snp_global = 1'b0, snp_inhibit = 1'b0, snp_burst = 1'b0;
   logic          late_window = 1'b0;
   logic          fill_ack_last = 1'b0;
   logic [IW-1:0] fill_slot = '0;
   logic [AW-1:0] fill_addr = '0;
   logic [1:0]    fill_state = '0;
   logic          resv_valid = 1'b0;
   logic [AW-1:0] resv_addr = '0;
   logic          push_ack = 1'b0;
   logic          snp_retry, push_req, upd_valid, resv_cancel;
   logic [AW-1:0] push_addr;
   logic [IW-1:0] upd_slot;
   logic [1:0]    upd_state;

   int n_chk = 0;
   int n_fail = 0;
   int m_st [LINES];
   logic [AW-1:0] m_addr [LINES];

   always #10 clk = ~clk;

   snp_resp_ctrl #(.LINES(LINES), .AW(AW)) dut (.*);

   function automatic logic [AW-1:0] pa(input int i);
      return AW'(64 * i + 3);
   endfunction

   // Specification of the response: push flag and next state for a hit in state st.
   function automatic void ref_resp(input int k, input int st, input bit g, input bit ci,
                                    input bit bu, output bit push, output int nst);
      push = 1'b0;
      nst  = st;
      if (st != 0) begin
         case (k)
            0, 1: begin
               if (ci) begin
                  if (st == 2) begin push = 1'b1; nst = 1; end
               end else if (g || bu) begin
                  push = (st == 2);
                  nst  = 0;
               end
            end
            2, 3, 5: begin push = (st == 2); nst = 0; end
            6: if (st == 2) begin push = 1'b1; nst = 1; end
            4, 7: nst = 0;
            default: nst = st;
         endcase
      end
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic snoop(input int k, input int ai, input bit g, input bit ci, input bit bu,
                        input string req);
      int  s, st, nst, d;
      bit  hit, push, exp_cancel, exp_upd;
      s = ai % LINES;
      @(negedge clk);
      snp_valid = 1'b1; snp_kind = 4'(k); snp_addr = pa(ai);
      snp_global = g; snp_inhibit = ci; snp_burst = bu;
      #5;
      hit = (m_st[s] != 0) && (m_addr[s] == pa(ai));
      st  = hit ? m_st[s] : 0;
      ref_resp(k, st, g, ci, bu, push, nst);
      exp_cancel = hit && k == 4 && resv_valid && resv_addr == pa(ai);
      exp_upd    = hit && !push && nst != st;
      chk(req, "retry", snp_retry, push);
      chk(req, "cancel", resv_cancel, exp_cancel);
      chk(req, "upd_valid", upd_valid, exp_upd);
      if (exp_upd) begin
         chk(req, "upd_slot", upd_slot, s);
         chk(req, "upd_state", upd_state, nst);
      end
      @(posedge clk); #1;
      snp_valid = 1'b0;
      if (exp_upd) m_st[s] = nst;
      if (push) begin
         @(negedge clk); #5;
         chk("R10", "push_req rise", push_req, 1);
         chk("R10", "push_addr", push_addr, pa(ai));
         d = $urandom % 4;
         for (int j = 0; j < d; j++) begin
            int kb;
            kb = $urandom % 16;
            @(negedge clk);
            snp_valid = 1'b1; snp_kind = 4'(kb); snp_addr = pa($urandom % 8);
            #5;
            chk("R10", "busy retry", snp_retry, kb <= 7);
            chk("R10", "busy push_req", push_req, 1);
            chk("R10", "busy no update", upd_valid, 0);
            @(posedge clk); #1;
            snp_valid = 1'b0;
         end
         @(negedge clk);
         push_ack = 1'b1;
         #5;
         chk(req, "commit upd_valid", upd_valid, 1);
         chk(req, "commit slot", upd_slot, s);
         chk(req, "commit state", upd_state, nst);
         @(posedge clk); #1;
         push_ack = 1'b0;
         m_st[s] = nst;
         @(negedge clk); #5;
         chk("R10", "push_req drop", push_req, 0);
      end
   endtask

   task automatic fill(input int ai, input int st, input int sk);
      int  s, ss;
      bit  shit;
      s  = ai % LINES;
      ss = (ai + 1) % LINES;
      @(negedge clk);
      fill_ack_last = 1'b1; fill_slot = IW'(s); fill_addr = pa(ai); fill_state = 2'(st);
      if (!late_window) begin
         snp_valid = (sk >= 0); snp_kind = 4'(sk); snp_addr = pa((ai + 1) % 8);
         snp_global = 1'b1; snp_inhibit = 1'b0; snp_burst = 1'b0;
         #5;
         chk("R3", "ack-cycle retry", snp_retry, sk >= 0 && sk <= 7);
         chk("R3", "ack-cycle no update", upd_valid, 0);
         @(posedge clk); #1;
         fill_ack_last = 1'b0; snp_valid = 1'b0;
         m_st[s] = st; m_addr[s] = pa(ai);
      end else begin
         snp_valid = 1'b1; snp_kind = 4'd7; snp_addr = pa((ai + 1) % 8);
         #5;
         shit = (m_st[ss] != 0) && (m_addr[ss] == pa((ai + 1) % 8));
         chk("R4", "ack-cycle served", snp_retry, 0);
         chk("R4", "ack-cycle kill update", upd_valid, shit);
         @(posedge clk); #1;
         if (shit) m_st[ss] = 0;
         fill_ack_last = 1'b0; snp_valid = 1'b0;
         @(negedge clk);
         snp_valid = 1'b1; snp_kind = 4'(sk < 0 ? 5 : sk % 8); snp_addr = pa(ai);
         #5;
         chk("R4", "late-cycle retry", snp_retry, 1);
         chk("R4", "late-cycle no update", upd_valid, 0);
         @(posedge clk); #1;
         snp_valid = 1'b0;
         m_st[s] = st; m_addr[s] = pa(ai);
      end
   endtask

   initial begin
      #4_000_000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_addr[i] = '0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk); #5;
      chk("R12", "retry", snp_retry, 0);
      chk("R12", "push_req", push_req, 0);
      chk("R12", "upd_valid", upd_valid, 0);
      chk("R12", "resv_cancel", resv_cancel, 0);
      snoop(0, 0, 1, 0, 0, "R11");            // miss after reset
      snoop(4, 1, 1, 0, 0, "R11");

      fill(0, 2, -1); snoop(5, 0, 0, 0, 0, "R1");      // flush M
      fill(1, 2, -1); snoop(6, 1, 0, 0, 0, "R1");      // clean M -> E
      snoop(6, 1, 0, 0, 0, "R1");                      // clean E: nothing
      fill(2, 1, -1); snoop(5, 2, 0, 0, 0, "R1");      // flush E
      fill(3, 2, -1); snoop(7, 3, 0, 0, 0, "R2");      // kill M
      resv_valid = 1'b1; resv_addr = pa(4);
      fill(4, 2, -1); snoop(4, 4, 0, 0, 0, "R5");      // write-with-kill M
      resv_addr = pa(6);
      fill(5, 1, -1); snoop(4, 5, 0, 0, 0, "R11");     // reservation elsewhere
      fill(6, 2, -1); snoop(2, 6, 0, 0, 0, "R11");     // hit, no cancel for RWITM
      resv_valid = 1'b0;
      fill(0, 1, -1); snoop(0, 0, 1, 0, 0, "R6");
      fill(0, 2, -1); snoop(1, 0, 1, 0, 0, "R6");
      fill(1, 2, -1); snoop(0, 1, 0, 0, 1, "R6");      // burst
      fill(2, 2, -1); snoop(0, 2, 0, 0, 0, "R6");      // neither: nothing
      fill(3, 1, -1); snoop(0, 3, 1, 1, 0, "R7");
      fill(3, 2, -1); snoop(1, 3, 1, 1, 1, "R7");
      fill(4, 1, -1); snoop(2, 4, 0, 0, 0, "R8");
      fill(5, 2, -1); snoop(3, 5, 0, 0, 0, "R8");
      fill(6, 2, -1); snoop(8, 6, 1, 0, 0, "R9");
      snoop(9, 6, 1, 0, 0, "R9");
      snoop(12, 6, 1, 0, 0, "R13");
      fill(7, 2, 5); fill(6, 1, 0);                     // R3 collisions
      late_window = 1'b1;
      fill(2, 2, 2); fill(7, 1, -1);                    // R4 collisions
      snoop(5, 7, 0, 0, 0, "R4");
      late_window = 1'b0;

      for (int it = 0; it < 400; it++) begin
         resv_valid = $urandom % 2;
         resv_addr  = pa($urandom % 8);
         if ($urandom % 8 == 0) begin
            late_window = $urandom % 2;
            fill($urandom % 8, 1 + $urandom % 2, int'($urandom % 12) - 2);
            late_window = 1'b0;
         end else begin
            snoop($urandom % 16, $urandom % 8, $urandom % 2, ($urandom % 4) == 0,
                  $urandom % 2, "R13");
         end
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule